// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block watches the command pins of a synchronous DRAM interface once per clock and turns each sample into a named memory command. It also keeps a model of the memory's four banks: which of them are open, and which row each one last opened. A controller or monitor uses the outputs to see what the memory believes its state to be. The illegal-command flag catches sequences that a real device would reject: accesses to closed banks, double activates, maintenance commands while rows are open, and any traffic before the mode word has been loaded.

Every output is registered. A command sampled at one rising edge shows up on `cmd_o` and `illegal_o` right after that edge. The bank flags, the row registers and the mode-valid flag move at the same edge. A write with auto-precharge leaves its bank open while the burst runs. The bank closes by itself once the programmed number of beats has passed. The burst length comes from the last mode register load.

Top module: `sdram_bank_tracker`

## Requirements
- R1: With `chip_sel_n_i` high the command is DESEL (code 0). With it low, the levels {row, col, write} of `row_strobe_n_i`, `col_strobe_n_i` and `wr_en_n_i` decode as follows:
  - 111 is NOP (1).
  - 011 is ACT (2).
  - 101 is READ (3).
  - 100 is WRITE (4), or WRITE_AP (5) when `addr_i[10]` is 1.
  - 010 is PRE (6), or PALL (7) when `addr_i[10]` is 1.
  - 001 is AREF (8) when `clk_en_i` is 1, or SREF (9) when it is 0.
  - 000 is MRS (10).
  - 110 is BST (11).
  
  The code appears on `cmd_o` after the edge that sampled it.
- R2: The bank index is {`bank_sel_hi_i`, `bank_sel_lo_i`}. Bank b drives `bank_open_o[b]` and `bank_row_o[13*b+12 : 13*b]`.
- R3: A legal ACT sets the selected bank's open flag and loads its row register with `addr_i[12:0]`. The other banks are not affected.
- R4: A legal PRE closes only the selected bank, and a PRE to a bank that is already closed is legal. A legal PALL closes all four banks.
- R5: A legal WRITE_AP keeps its bank open and closes it after exactly N further edges. N comes from the last MRS word: `addr_i[2:0]` = 0, 1, 2, 3 gives 1, 2, 4, 8 beats, and any other value gives 1. If `addr_i[9]` was 1, N is 1 (single write). A new WRITE_AP to the same bank restarts the count.
- R6: `mode_valid_o` is 0 after reset. It becomes 1 after the first legal MRS and stays 1 until reset.
- R7: While `mode_valid_o` is 0, every command other than DESEL, NOP and MRS raises `illegal_o`.
- R8: READ, WRITE or WRITE_AP to a closed bank raises `illegal_o`, and so does ACT to an open bank.
- R9: MRS, AREF and SREF are illegal while any bank is open. With all banks closed they are legal.
- R10: An illegal command changes no open flag, row register or mode state, although running auto-precharge counts continue. `illegal_o` stays high for that one cycle only, and DESEL or NOP never raises it.
- R11: After synchronous reset (`rst_n` low at an edge) all banks are closed, every row register is 0, `mode_valid_o` is 0, `illegal_o` is 0 and `cmd_o` is DESEL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| chip_sel_n_i | input | 1 | Chip select, active low |
| row_strobe_n_i | input | 1 | Row strobe, active low |
| col_strobe_n_i | input | 1 | Column strobe, active low |
| wr_en_n_i | input | 1 | Write enable, active low |
| clk_en_i | input | 1 | Clock enable level; selects self-refresh on a refresh command |
| bank_sel_hi_i | input | 1 | High bit of the bank index |
| bank_sel_lo_i | input | 1 | Low bit of the bank index |
| addr_i | input | 13 | Row address, mode word, bit 10 as the auto-precharge/all-banks qualifier |
| cmd_o | output | 4 | Decoded command code |
| illegal_o | output | 1 | One-cycle flag for a rejected command |
| mode_valid_o | output | 1 | Mode register has been loaded |
| bank_open_o | output | 4 | Open flag per bank |
| bank_row_o | output | 52 | Row register per bank, 13 bits each |

## Verification
A wrong bank flag inside the tracker has visible effects. It shows on `bank_open_o` straight after the faulty edge. It also shows one command later as a wrong `illegal_o` when the next ACT, READ or maintenance command reaches that bank. A miscounted auto-precharge shows as a bank that closes one or more edges early or late. For that reason the bank flags are compared at every edge of each burst, at 1, 4 and 8 beats and on a restarted count. A bank index with its bits swapped shows at once as the wrong flag being set. The test activates banks 1 and 2, where a swap cannot go unnoticed.

// File: rtl/sdram_trk_pkg.sv
// Package: command codes and pin decode shared by the tracker and its checker.
// Assumes active-low strobes sampled on the rising clock edge.
package sdram_trk_pkg;

    typedef enum logic [3:0] {
        CMD_DESEL    = 4'd0,
        CMD_NOP      = 4'd1,
        CMD_ACT      = 4'd2,
        CMD_READ     = 4'd3,
        CMD_WRITE    = 4'd4,
        CMD_WRITE_AP = 4'd5,
        CMD_PRE      = 4'd6,
        CMD_PALL     = 4'd7,
        CMD_AREF     = 4'd8,
        CMD_SREF     = 4'd9,
        CMD_MRS      = 4'd10,
        CMD_BST      = 4'd11
    } cmd_e;

    // Map one pin sample to a command code.
    function automatic cmd_e decode_pins(input logic cs_n, input logic rs_n,
                                         input logic cs2_n, input logic we_n,
                                         input logic qual, input logic cke);
        cmd_e c;
        if (cs_n) begin
            c = CMD_DESEL;
        end else begin
            case ({rs_n, cs2_n, we_n})
                3'b111:  c = CMD_NOP;
                3'b011:  c = CMD_ACT;
                3'b101:  c = CMD_READ;
                3'b100:  c = qual ? CMD_WRITE_AP : CMD_WRITE;
                3'b010:  c = qual ? CMD_PALL : CMD_PRE;
                3'b001:  c = cke ? CMD_AREF : CMD_SREF;
                3'b000:  c = CMD_MRS;
                default: c = CMD_BST;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
// Module: sdram_cmd_decode
// Decodes the pin sample and judges it against the current bank and mode
// state. It then emits one-hot per-bank strobes for legal commands only.
// Assumes bank_open_i and mode_valid_i are the registered pre-edge state.
module sdram_cmd_decode
    import sdram_trk_pkg::*;
#(
    parameter int BANK_W    = 2,
    localparam int NUM_BANKS = 1 << BANK_W
) (
    input  logic                 cs_n_i,
    input  logic                 rs_n_i,
    input  logic                 col_n_i,
    input  logic                 we_n_i,
    input  logic                 qual_i,
    input  logic                 cke_i,
    input  logic [BANK_W-1:0]    bank_i,
    input  logic [NUM_BANKS-1:0] bank_open_i,
    input  logic                 mode_valid_i,
    output cmd_e                 cmd_o,
    output logic                 illegal_o,
    output logic [NUM_BANKS-1:0] act_o,
    output logic [NUM_BANKS-1:0] close_o,
    output logic [NUM_BANKS-1:0] wap_o,
    output logic                 mrs_o
);

    cmd_e                 cmd;
    logic [NUM_BANKS-1:0] sel;
    logic                 target_open;
    logic                 any_open;
    logic                 bad;

    // Pin decode and one-hot bank select.
    always_comb begin
        cmd         = decode_pins(cs_n_i, rs_n_i, col_n_i, we_n_i, qual_i, cke_i);
        sel         = '0;
        sel[bank_i] = 1'b1;
        target_open = bank_open_i[bank_i];
        any_open    = |bank_open_i;
    end

    // Legality rules against bank and mode state.
    always_comb begin
        case (cmd)
            CMD_ACT:                          bad = target_open;
            CMD_READ, CMD_WRITE, CMD_WRITE_AP: bad = !target_open;
            CMD_MRS, CMD_AREF, CMD_SREF:       bad = any_open;
            default:                          bad = 1'b0;
        endcase
        if (!mode_valid_i && cmd != CMD_DESEL && cmd != CMD_NOP && cmd != CMD_MRS) begin
            bad = 1'b1;
        end
    end

    // Per-bank strobes, issued only when the command is legal.
    always_comb begin
        act_o   = '0;
        close_o = '0;
        wap_o   = '0;
        mrs_o   = 1'b0;
        if (!bad) begin
            case (cmd)
                CMD_ACT:      act_o   = sel;
                CMD_PRE:      close_o = sel;
                CMD_PALL:     close_o = '1;
                CMD_WRITE_AP: wap_o   = sel;
                CMD_MRS:      mrs_o   = 1'b1;
                default:      ;
            endcase
        end
    end

    assign cmd_o     = cmd;
    assign illegal_o = bad;

endmodule

// File: rtl/sdram_mode_reg.sv
// Module: sdram_mode_reg
// Holds the validity flag and the write-burst beat count taken from the
// mode word. Assumes mrs_i is already qualified as legal.
module sdram_mode_reg #(
    parameter int CNT_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_n,
    input  logic             mrs_i,
    input  logic [2:0]       len_code_i,
    input  logic             single_i,
    output logic             valid_o,
    output logic [CNT_W-1:0] beats_o
);

    logic [CNT_W-1:0] beats_next;

    // Beat count for the new mode word: 1, 2, 4 or 8, reserved codes give 1.
    always_comb begin
        if (single_i || len_code_i[2]) begin
            beats_next = CNT_W'(1);
        end else begin
            beats_next = CNT_W'(1) << len_code_i[1:0];
        end
    end

    // Load the mode on a legal MRS; validity is sticky until reset.
    always_ff @(posedge clk_i) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            beats_o <= CNT_W'(1);
        end else if (mrs_i) begin
            valid_o <= 1'b1;
            beats_o <= beats_next;
        end
    end

endmodule

// File: rtl/sdram_bank_slot.sv
// Module: sdram_bank_slot
// One bank: open flag, row register and auto-precharge countdown.
// Assumes at most one of act_i, close_i, wap_i is high in a cycle.
module sdram_bank_slot #(
    parameter int ROW_W = 13,
    parameter int CNT_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_n,
    input  logic             act_i,
    input  logic             close_i,
    input  logic             wap_i,
    input  logic [CNT_W-1:0] beats_i,
    input  logic [ROW_W-1:0] row_i,
    output logic             open_o,
    output logic [ROW_W-1:0] row_o
);

    logic [CNT_W-1:0] remain;

    // Bank state update: close, open, arm countdown, or count down.
    always_ff @(posedge clk_i) begin
        if (!rst_n) begin
            open_o <= 1'b0;
            row_o  <= '0;
            remain <= '0;
        end else if (close_i) begin
            open_o <= 1'b0;
            remain <= '0;
        end else if (act_i) begin
            open_o <= 1'b1;
            row_o  <= row_i;
            remain <= '0;
        end else if (wap_i) begin
            remain <= beats_i;
        end else if (remain != '0) begin
            remain <= remain - CNT_W'(1);
            if (remain == CNT_W'(1)) begin
                open_o <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sdram_bank_tracker.sv
// Module: sdram_bank_tracker (top)
// Registers the decoded command and illegal flag and instantiates the
// mode register and one slot per bank. Assumes the pins are synchronous
// to clk_i.
module sdram_bank_tracker
    import sdram_trk_pkg::*;
#(
    parameter int BANK_W    = 2,
    parameter int ROW_W     = 13,
    parameter int MAX_BURST = 8,
    localparam int NUM_BANKS = 1 << BANK_W,
    localparam int CNT_W     = $clog2(MAX_BURST + 1)
) (
    input  logic                       clk_i,
    input  logic                       rst_n,
    input  logic                       chip_sel_n_i,
    input  logic                       row_strobe_n_i,
    input  logic                       col_strobe_n_i,
    input  logic                       wr_en_n_i,
    input  logic                       clk_en_i,
    input  logic                       bank_sel_hi_i,
    input  logic                       bank_sel_lo_i,
    input  logic [ROW_W-1:0]           addr_i,
    output logic [3:0]                 cmd_o,
    output logic                       illegal_o,
    output logic                       mode_valid_o,
    output logic [NUM_BANKS-1:0]       bank_open_o,
    output logic [NUM_BANKS*ROW_W-1:0] bank_row_o
);

    cmd_e                 dec_cmd;
    logic                 dec_bad;
    logic [NUM_BANKS-1:0] act_s;
    logic [NUM_BANKS-1:0] close_s;
    logic [NUM_BANKS-1:0] wap_s;
    logic                 mrs_s;
    logic [CNT_W-1:0]     beats;
    logic [BANK_W-1:0]    bank_idx;
    cmd_e                 cmd_q;
    logic                 bad_q;

    assign bank_idx = {bank_sel_hi_i, bank_sel_lo_i};

    sdram_cmd_decode #(.BANK_W(BANK_W)) u_dec (
        .cs_n_i       (chip_sel_n_i),
        .rs_n_i       (row_strobe_n_i),
        .col_n_i      (col_strobe_n_i),
        .we_n_i       (wr_en_n_i),
        .qual_i       (addr_i[10]),
        .cke_i        (clk_en_i),
        .bank_i       (bank_idx),
        .bank_open_i  (bank_open_o),
        .mode_valid_i (mode_valid_o),
        .cmd_o        (dec_cmd),
        .illegal_o    (dec_bad),
        .act_o        (act_s),
        .close_o      (close_s),
        .wap_o        (wap_s),
        .mrs_o        (mrs_s)
    );

    sdram_mode_reg #(.CNT_W(CNT_W)) u_mode (
        .clk_i      (clk_i),
        .rst_n      (rst_n),
        .mrs_i      (mrs_s),
        .len_code_i (addr_i[2:0]),
        .single_i   (addr_i[9]),
        .valid_o    (mode_valid_o),
        .beats_o    (beats)
    );

    // One tracking slot per bank.
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic [ROW_W-1:0] row_w;
        sdram_bank_slot #(.ROW_W(ROW_W), .CNT_W(CNT_W)) u_slot (
            .clk_i   (clk_i),
            .rst_n   (rst_n),
            .act_i   (act_s[g]),
            .close_i (close_s[g]),
            .wap_i   (wap_s[g]),
            .beats_i (beats),
            .row_i   (addr_i),
            .open_o  (bank_open_o[g]),
            .row_o   (row_w)
        );
        assign bank_row_o[g*ROW_W +: ROW_W] = row_w;
    end

    // Output register for the command code and the illegal flag.
    always_ff @(posedge clk_i) begin
        if (!rst_n) begin
            cmd_q <= CMD_DESEL;
            bad_q <= 1'b0;
        end else begin
            cmd_q <= dec_cmd;
            bad_q <= dec_bad;
        end
    end

    assign cmd_o     = cmd_q;
    assign illegal_o = bad_q;

endmodule

// File: rtl/sdram_bank_tracker_chk.sv
// Module: sdram_bank_tracker_chk
// Property checker bound to the tracker top; observes ports only.
module sdram_bank_tracker_chk
    import sdram_trk_pkg::*;
#(
    parameter int ROW_W = 13
) (
    input logic                 clk_i,
    input logic                 rst_n,
    input logic                 bank_sel_hi_i,
    input logic                 bank_sel_lo_i,
    input logic [ROW_W-1:0]     addr_i,
    input logic [3:0]           cmd_o,
    input logic                 illegal_o,
    input logic                 mode_valid_o,
    input logic [3:0]           bank_open_o,
    input logic [4*ROW_W-1:0]   bank_row_o
);

    logic [1:0]       idx_q;
    logic [ROW_W-1:0] addr_q;

    // Remember the bank and address that go with the registered command.
    always_ff @(posedge clk_i) begin
        idx_q  <= {bank_sel_hi_i, bank_sel_lo_i};
        addr_q <= addr_i;
    end

    AST_ACT_OPENS_ROW: assert property (@(posedge clk_i) disable iff (!rst_n)
        (cmd_o == CMD_ACT && !illegal_o) |->
            (bank_open_o[idx_q] && bank_row_o[idx_q*ROW_W +: ROW_W] == addr_q)); // R3
    AST_PALL_CLOSES_ALL: assert property (@(posedge clk_i) disable iff (!rst_n)
        (cmd_o == CMD_PALL && !illegal_o) |-> (bank_open_o == 4'b0000)); // R4
    AST_MODE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_n)
        $past(mode_valid_o) |-> mode_valid_o); // R6
    AST_EARLY_FLAG: assert property (@(posedge clk_i) disable iff (!rst_n)
        (!$past(mode_valid_o) && cmd_o != CMD_DESEL && cmd_o != CMD_NOP && cmd_o != CMD_MRS)
            |-> illegal_o); // R7
    AST_BUSY_MAINT: assert property (@(posedge clk_i) disable iff (!rst_n)
        ((cmd_o == CMD_MRS || cmd_o == CMD_AREF || cmd_o == CMD_SREF) && $past(bank_open_o) != 4'b0000)
            |-> illegal_o); // R9
    AST_IDLE_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_n)
        (cmd_o == CMD_DESEL || cmd_o == CMD_NOP) |-> !illegal_o); // R10
    AST_ILLEGAL_KEEPS_ROWS: assert property (@(posedge clk_i) disable iff (!rst_n)
        illegal_o |-> $stable(bank_row_o)); // R10

endmodule

bind sdram_bank_tracker sdram_bank_tracker_chk #(.ROW_W(ROW_W)) u_chk (
    .clk_i         (clk_i),
    .rst_n         (rst_n),
    .bank_sel_hi_i (bank_sel_hi_i),
    .bank_sel_lo_i (bank_sel_lo_i),
    .addr_i        (addr_i),
    .cmd_o         (cmd_o),
    .illegal_o     (illegal_o),
    .mode_valid_o  (mode_valid_o),
    .bank_open_o   (bank_open_o),
    .bank_row_o    (bank_row_o)
);

// File: tb/sdram_bank_tracker_bench.sv
// Scoreboard bench: the driver applies a command, updates a reference model
// built from the requirements and queues the expected outputs; the monitor
// compares them one time unit after each rising edge.
module sdram_bank_tracker_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, rs_n = 1'b1, cl_n = 1'b1, we_n = 1'b1, cke = 1'b1;
    logic        b_hi = 1'b0, b_lo = 1'b0;
    logic [12:0] addr = '0;
    logic [3:0]  cmd;
    logic        illegal, mvalid;
    logic [3:0]  opn;
    logic [51:0] rows;

    always #2 clk = ~clk;

    sdram_bank_tracker u_sdram_bank_tracker (
        .clk_i(clk), .rst_n(rst_n), .chip_sel_n_i(cs_n), .row_strobe_n_i(rs_n),
        .col_strobe_n_i(cl_n), .wr_en_n_i(we_n), .clk_en_i(cke),
        .bank_sel_hi_i(b_hi), .bank_sel_lo_i(b_lo), .addr_i(addr),
        .cmd_o(cmd), .illegal_o(illegal), .mode_valid_o(mvalid),
        .bank_open_o(opn), .bank_row_o(rows));

    typedef struct {
        logic [3:0]  cmd;
        logic        ill;
        logic        mv;
        logic [3:0]  opn;
        logic [51:0] rows;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;

    // Reference model state.
    logic [3:0]  m_open = '0;
    logic [51:0] m_rows = '0;
    int          m_cnt[4] = '{0, 0, 0, 0};
    logic        m_mv = 1'b0;
    int          m_beats = 1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Monitor: pop and compare one expected item per rising edge.
    always @(posedge clk) begin
        #1;
        if (rst_n && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            chk(cmd === e.cmd, e.tag, "cmd", 64'(cmd), 64'(e.cmd));
            chk(illegal === e.ill, e.tag, "illegal", 64'(illegal), 64'(e.ill));
            chk(mvalid === e.mv, e.tag, "mode_valid", 64'(mvalid), 64'(e.mv));
            chk(opn === e.opn, e.tag, "bank_open", 64'(opn), 64'(e.opn));
            chk(rows === e.rows, e.tag, "bank_row", 64'(rows), 64'(e.rows));
        end
    end

    // Driver: apply pins at the falling edge and queue the model's result.
    task automatic issue(input logic c, input logic r, input logic l, input logic w,
                         input int bank, input logic [12:0] a, input logic k,
                         input string tag);
        int   code;
        logic bad;
        exp_t e;
        @(negedge clk);
        cs_n = c; rs_n = r; cl_n = l; we_n = w; cke = k;
        b_hi = bank[1]; b_lo = bank[0]; addr = a;
        // R1 code table
        if (c) code = 0;
        else case ({r, l, w})
            3'b111: code = 1;
            3'b011: code = 2;
            3'b101: code = 3;
            3'b100: code = a[10] ? 5 : 4;
            3'b010: code = a[10] ? 7 : 6;
            3'b001: code = k ? 8 : 9;
            3'b000: code = 10;
            default: code = 11;
        endcase
        // R7, R8, R9 legality
        case (code)
            2: bad = m_open[bank];
            3, 4, 5: bad = !m_open[bank];
            8, 9, 10: bad = |m_open;
            default: bad = 1'b0;
        endcase
        if (!m_mv && code != 0 && code != 1 && code != 10) bad = 1'b1;
        // Per-bank update, R3 R4 R5
        for (int b = 0; b < 4; b++) begin
            if (!bad && (code == 7 || (code == 6 && b == bank))) begin
                m_open[b] = 1'b0; m_cnt[b] = 0;
            end else if (!bad && code == 2 && b == bank) begin
                m_open[b] = 1'b1; m_rows[b*13 +: 13] = a; m_cnt[b] = 0;
            end else if (!bad && code == 5 && b == bank) begin
                m_cnt[b] = m_beats;
            end else if (m_cnt[b] != 0) begin
                if (m_cnt[b] == 1) m_open[b] = 1'b0;
                m_cnt[b] = m_cnt[b] - 1;
            end
        end
        // R6 mode load
        if (!bad && code == 10) begin
            m_mv = 1'b1;
            if (a[9] || a[2]) m_beats = 1;
            else m_beats = 1 << a[1:0];
        end
        e.cmd = 4'(code); e.ill = bad; e.mv = m_mv; e.opn = m_open;
        e.rows = m_rows; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic nop(input string tag);      issue(0, 1, 1, 1, 0, 13'h0, 1, tag); endtask
    task automatic act(input int b, input logic [12:0] row, input string tag);
        issue(0, 0, 1, 1, b, row, 1, tag); endtask
    task automatic rd(input int b, input string tag);  issue(0, 1, 0, 1, b, 13'h0, 1, tag); endtask
    task automatic wr(input int b, input logic ap, input string tag);
        issue(0, 1, 0, 0, b, {2'b0, ap, 10'h0}, 1, tag); endtask
    task automatic pre(input int b, input logic all, input string tag);
        issue(0, 0, 1, 0, b, {2'b0, all, 10'h0}, 1, tag); endtask
    task automatic refr(input logic k, input string tag) ; issue(0, 0, 0, 1, 0, 13'h0, k, tag); endtask
    task automatic mrs(input logic [12:0] w, input string tag); issue(0, 0, 0, 0, 0, w, 1, tag); endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        nop("R11 reset state");
        act(1, 13'h0AAA, "R7 act before mode");
        refr(1, "R7 refresh before mode");
        issue(0, 1, 1, 0, 0, 13'h0, 1, "R7 bst before mode");
        nop("R10 flag clears");
        issue(1, 0, 0, 0, 0, 13'h0, 1, "R1 deselect");
        mrs(13'h002, "R6 mrs burst4");
        nop("R6 sticky");
        act(1, 13'h1ABC, "R2 R3 act bank1");
        act(2, 13'h0123, "R2 R3 act bank2");
        act(1, 13'h0555, "R8 R10 act open bank");
        rd(3, "R8 read closed");
        wr(0, 0, "R8 write closed");
        rd(1, "R1 read open");
        wr(2, 0, "R1 write open");
        mrs(13'h003, "R9 mrs busy");
        refr(1, "R9 refresh busy");
        refr(0, "R9 selfref busy");
        issue(0, 1, 1, 0, 0, 13'h0, 1, "R1 bst");
        wr(1, 1, "R5 write ap bl4");
        for (int i = 0; i < 5; i++) nop("R5 bl4 countdown");
        act(0, 13'h1FFF, "R3 act bank0");
        act(3, 13'h0001, "R3 act bank3");
        pre(2, 0, "R4 pre bank2 only");
        pre(2, 0, "R4 pre closed bank");
        pre(0, 1, "R4 precharge all");
        refr(1, "R9 auto refresh idle");
        refr(0, "R9 self refresh idle");
        mrs(13'h203, "R5 mrs single write");
        act(0, 13'h0F0F, "R3 act bank0 again");
        wr(0, 1, "R5 single write ap");
        nop("R5 single closes");
        nop("R5 single settled");
        mrs(13'h003, "R5 mrs burst8");
        act(3, 13'h0777, "R3 act bank3 again");
        wr(3, 1, "R5 write ap bl8");
        for (int i = 0; i < 4; i++) nop("R5 bl8 countdown");
        wr(3, 1, "R5 restart count");
        for (int i = 0; i < 9; i++) nop("R5 restarted countdown");
        mrs(13'h005, "R5 reserved code");
        act(2, 13'h0321, "R3 act bank2 again");
        wr(2, 1, "R5 reserved is one beat");
        nop("R5 reserved closes");
        wr(2, 1, "R8 write after autoclose");
        nop("R10 final");
        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule